// File: doc/BRIEF.md
# Receive Lane Bring-Up Sequencer

This block powers up and starts a single high-speed serial receive lane. A one-cycle start pulse launches a fixed series of steps on six control lines toward the analog lane: auxiliary power-down, sleep, calibration enable, data enable, clock-data-recovery (CDR) reset and PCS PHY-ready. Each gap between steps is a minimum wait taken from a down-counter, never from a handshake. The block waits for two things, a calibration-complete input and a PCS link-status input, and each wait has its own timeout.

The step that matters most is the handling of CDR reset. PHY-ready is held low before CDR reset is asserted. PHY-ready is raised again while CDR reset is still held, and CDR reset is kept asserted for a long settle time after that. This ordering puts valid data on the receiver inputs before the CDR begins to lock. Once CDR reset is released, link status is sampled on a slow fixed period for a bounded number of samples. The result is either a sticky done flag or a two-bit error code.

Every wait is set in nanoseconds through a parameter. It is converted to clock cycles, rounded up, using a clock-frequency parameter, so each wait lasts at least its nominal time. Below, STEP, CALWAIT, CALTO, HOLD and POLL are those cycle counts, and POLL_MAX is the number of link samples.

Top module: `rxlane_bringup`

## Requirements
- R1: After synchronous reset, laneIddq=1 and laneSleep=1. calEn, dataEn, cdrReset, phyRdy and done are 0 and errCode=00. The outputs stay that way until start is sampled high.
- R2: When start is sampled high in idle, done or an error state, laneIddq drops at that clock edge while laneSleep stays high. laneSleep drops STEP cycles later.
- R3: calEn rises exactly CALWAIT cycles after laneSleep drops, and only while laneSleep is low.
- R4: If calDone is not sampled high within CALTO cycles of calEn rising, all lane controls return to the reset values and errCode becomes 01 (calibration timeout).
- R5: calDone is looked at only while calibration is running. The edge that samples it high drops calEn, and dataEn rises STEP cycles after that edge. calDone held high earlier does not shorten any wait.
- R6: phyRdy is low when dataEn rises and stays low for STEP cycles. cdrReset then rises while phyRdy is still low.
- R7: STEP cycles after cdrReset rises, phyRdy rises while cdrReset stays high.
- R8: cdrReset stays high for HOLD cycles after phyRdy rises. It then falls while phyRdy stays high.
- R9: linkUp is sampled once every POLL cycles, with the first sample POLL cycles after cdrReset falls. The first sample seen high raises done at that edge. done then holds, whatever linkUp does, until the next start.
- R10: If all POLL_MAX samples of linkUp are low, all lane controls return to the reset values and errCode becomes 10 (link timeout).
- R11: A start sampled while a sequence is running returns every lane control to its reset value at that edge. The block then stays idle until it samples another start.
- R12: errCode never takes the value 11, and done is never high while errCode is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin (or abort) a bring-up |
| calDone | input | 1 | Lane calibration finished |
| linkUp | input | 1 | PCS link status |
| laneIddq | output | 1 | Auxiliary receive power-down, 1 = powered down |
| laneSleep | output | 1 | Receive sleep, 1 = asleep |
| calEn | output | 1 | Calibration enable |
| dataEn | output | 1 | Receive data enable |
| cdrReset | output | 1 | CDR reset, 1 = held in reset |
| phyRdy | output | 1 | PCS PHY-ready |
| done | output | 1 | Link is up, sticky until the next start |
| errCode | output | 2 | 00 none, 01 calibration timeout, 10 link timeout |

## Verification
Every change of the output vector is checked against the exact clock edge and value predicted from the step counts. A design that swaps the PHY-ready drop and the CDR-reset rise, or releases CDR reset before PHY-ready returns, therefore shows up as a wrong value at a known edge. One run keeps calDone high from before start, which exposes a design that skips the wake wait or the post-calibration wait. Other runs let calibration or link polling run out, and a design that is off by one in its sample count, or leaves the lane powered after an error, reports the wrong edge or a wrong control value. A start arriving mid-hold must drop everything at once and then cause no further output change.

// File: rtl/rxlane_pkg.sv
package rxlane_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PWRUP, S_WAKE, S_CAL, S_CALSET, S_DROP,
    S_CDR, S_HOLD, S_POLL, S_DONE, S_ERRCAL, S_ERRLINK
  } seqState_e;

  typedef enum logic [2:0] {
    DUR_STEP, DUR_CALWAIT, DUR_CALTO, DUR_HOLD, DUR_POLL
  } dur_e;

  // strobes from the controller to the timing datapath
  typedef struct packed {
    logic load;    // restart the wait counter
    dur_e sel;     // which duration to load
    logic smpClr;  // clear the link-sample counter
    logic smpInc;  // count one failed link sample
  } tmrCmd_t;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_CAL  = 2'd1;
  localparam logic [1:0] ERR_LINK = 2'd2;

  // nanoseconds to clock cycles, rounded up, at least one
  function automatic int nsToCycles(longint ns, longint mhz);
    longint c;
    c = (ns * mhz + 64'sd999) / 64'sd1000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/rxlane_timer.sv
module rxlane_timer
  import rxlane_pkg::*;
#(
  parameter int STEP_C    = 7,
  parameter int CALWAIT_C = 63,
  parameter int CALTO_C   = 125000,
  parameter int HOLD_C    = 3750000,
  parameter int POLL_C    = 62500,
  parameter int POLL_MAX  = 2000,
  parameter int LONGEST_C = 3750000,
  parameter int CNT_W     = 22,
  parameter int SMP_W     = 11
) (
  input  logic    clk,
  input  logic    rst,
  input  tmrCmd_t cmd,
  output logic    expired,
  output logic    smpLast
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] durSel;
  logic [SMP_W-1:0] smp;

  always_comb begin
    case (cmd.sel)
      DUR_STEP:    durSel = CNT_W'(STEP_C - 1);
      DUR_CALWAIT: durSel = CNT_W'(CALWAIT_C - 1);
      DUR_CALTO:   durSel = CNT_W'(CALTO_C - 1);
      DUR_HOLD:    durSel = CNT_W'(HOLD_C - 1);
      DUR_POLL:    durSel = CNT_W'(POLL_C - 1);
      default:     durSel = CNT_W'(STEP_C - 1);
    endcase
  end

  // a state entered with a load lasts exactly duration cycles
  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (cmd.load)      cnt <= durSel;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || cmd.smpClr)  smp <= '0;
    else if (cmd.smpInc)    smp <= smp + 1'b1;
  end

  assign expired = (cnt == '0);
  assign smpLast = (smp == SMP_W'(POLL_MAX - 1));

  // R8: no wait, the long hold included, exceeds its loaded length
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(LONGEST_C - 1));

  // R10: the sample count never passes the last allowed sample
  p_smp_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cmd.smpInc |-> !smpLast);

endmodule

// File: rtl/rxlane_ctrl.sv
module rxlane_ctrl
  import rxlane_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       calDone,
  input  logic       linkUp,
  input  logic       expired,
  input  logic       smpLast,
  output tmrCmd_t    cmd,
  output logic       laneIddq,
  output logic       laneSleep,
  output logic       calEn,
  output logic       dataEn,
  output logic       cdrReset,
  output logic       phyRdy,
  output logic       done,
  output logic [1:0] errCode
);

  seqState_e st, nxt;
  logic      busy;

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= nxt;
  end

  always_comb begin
    nxt  = st;
    cmd  = '{load: 1'b0, sel: DUR_STEP, smpClr: 1'b0, smpInc: 1'b0};
    busy = !(st inside {S_IDLE, S_DONE, S_ERRCAL, S_ERRLINK});
    if (start) begin
      if (busy) nxt = S_IDLE;
      else begin
        nxt      = S_PWRUP;
        cmd.load = 1'b1;
        cmd.sel  = DUR_STEP;
      end
    end else begin
      case (st)
        S_PWRUP:  if (expired) begin nxt = S_WAKE; cmd.load = 1'b1; cmd.sel = DUR_CALWAIT; end
        S_WAKE:   if (expired) begin nxt = S_CAL;  cmd.load = 1'b1; cmd.sel = DUR_CALTO;   end
        S_CAL: begin
          if (calDone) begin nxt = S_CALSET; cmd.load = 1'b1; cmd.sel = DUR_STEP; end
          else if (expired) nxt = S_ERRCAL;
        end
        S_CALSET: if (expired) begin nxt = S_DROP; cmd.load = 1'b1; cmd.sel = DUR_STEP; end
        S_DROP:   if (expired) begin nxt = S_CDR;  cmd.load = 1'b1; cmd.sel = DUR_STEP; end
        S_CDR:    if (expired) begin nxt = S_HOLD; cmd.load = 1'b1; cmd.sel = DUR_HOLD; end
        S_HOLD: begin
          if (expired) begin
            nxt = S_POLL; cmd.load = 1'b1; cmd.sel = DUR_POLL; cmd.smpClr = 1'b1;
          end
        end
        S_POLL: begin
          if (expired) begin
            if (linkUp)       nxt = S_DONE;
            else if (smpLast) nxt = S_ERRLINK;
            else begin
              cmd.load = 1'b1; cmd.sel = DUR_POLL; cmd.smpInc = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign laneIddq  = (st inside {S_IDLE, S_ERRCAL, S_ERRLINK});
  assign laneSleep = laneIddq || (st == S_PWRUP);
  assign calEn     = (st == S_CAL);
  assign dataEn    = (st inside {S_DROP, S_CDR, S_HOLD, S_POLL, S_DONE});
  assign cdrReset  = (st inside {S_CDR, S_HOLD});
  assign phyRdy    = (st inside {S_HOLD, S_POLL, S_DONE});
  assign done      = (st == S_DONE);
  assign errCode   = (st == S_ERRCAL)  ? ERR_CAL :
                     (st == S_ERRLINK) ? ERR_LINK : ERR_NONE;

  p_iddq_first_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(laneSleep) |-> $past(!laneIddq));

  p_cal_after_wake_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(calEn) |-> $past(!laneSleep));

  p_cal_timeout_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(errCode == ERR_CAL) |-> ($past(calEn) && laneIddq && laneSleep));

  p_data_after_cal_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dataEn) |-> ($past(!calEn) && !phyRdy));

  p_rdy_low_at_cdr_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cdrReset) |-> ($past(!phyRdy) && !phyRdy && dataEn));

  p_rdy_under_cdr_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(phyRdy) |-> (cdrReset && $past(cdrReset)));

  p_cdr_release_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(cdrReset) && !laneIddq) |-> (phyRdy && $past(phyRdy)));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  p_link_timeout_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(errCode == ERR_LINK) |-> ($past(phyRdy && !cdrReset) && laneIddq));

  p_abort_r11: assert property (@(posedge clk) disable iff (rst)
    (start && dataEn && !done) |=> (laneIddq && laneSleep && !dataEn && !cdrReset && !phyRdy));

  p_err_code_r12: assert property (@(posedge clk) disable iff (rst)
    (errCode != 2'b11) && !(done && errCode != ERR_NONE));

endmodule

// File: rtl/rxlane_bringup.sv
module rxlane_bringup
  import rxlane_pkg::*;
#(
  parameter int CLK_MHZ    = 125,
  parameter int STEP_NS    = 50,
  parameter int CALWAIT_NS = 500,
  parameter int CALTO_NS   = 1_000_000,
  parameter int HOLD_NS    = 30_000_000,
  parameter int POLL_NS    = 500_000,
  parameter int POLL_MAX   = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       calDone,
  input  logic       linkUp,
  output logic       laneIddq,
  output logic       laneSleep,
  output logic       calEn,
  output logic       dataEn,
  output logic       cdrReset,
  output logic       phyRdy,
  output logic       done,
  output logic [1:0] errCode
);

  localparam int STEP_C    = nsToCycles(STEP_NS, CLK_MHZ);
  localparam int CALWAIT_C = nsToCycles(CALWAIT_NS, CLK_MHZ);
  localparam int CALTO_C   = nsToCycles(CALTO_NS, CLK_MHZ);
  localparam int HOLD_C    = nsToCycles(HOLD_NS, CLK_MHZ);
  localparam int POLL_C    = nsToCycles(POLL_NS, CLK_MHZ);
  localparam int MAX_A     = (STEP_C > CALWAIT_C) ? STEP_C : CALWAIT_C;
  localparam int MAX_B     = (MAX_A > CALTO_C) ? MAX_A : CALTO_C;
  localparam int MAX_D     = (MAX_B > HOLD_C) ? MAX_B : HOLD_C;
  localparam int LONGEST_C = (MAX_D > POLL_C) ? MAX_D : POLL_C;
  localparam int CNT_W     = $clog2(LONGEST_C + 1);
  localparam int SMP_W     = $clog2(POLL_MAX + 1);

  tmrCmd_t cmd;
  logic    expired;
  logic    smpLast;

  rxlane_ctrl ctrl_i (
    .clk(clk), .rst(rst), .start(start), .calDone(calDone), .linkUp(linkUp),
    .expired(expired), .smpLast(smpLast), .cmd(cmd),
    .laneIddq(laneIddq), .laneSleep(laneSleep), .calEn(calEn), .dataEn(dataEn),
    .cdrReset(cdrReset), .phyRdy(phyRdy), .done(done), .errCode(errCode)
  );

  rxlane_timer #(
    .STEP_C(STEP_C), .CALWAIT_C(CALWAIT_C), .CALTO_C(CALTO_C), .HOLD_C(HOLD_C),
    .POLL_C(POLL_C), .POLL_MAX(POLL_MAX), .LONGEST_C(LONGEST_C),
    .CNT_W(CNT_W), .SMP_W(SMP_W)
  ) timer_i (
    .clk(clk), .rst(rst), .cmd(cmd), .expired(expired), .smpLast(smpLast)
  );

endmodule

// File: tb/rxlane_bringup_tb_top.sv
`timescale 1ns/1ps
module rxlane_bringup_tb_top;

  // cycle counts at 125 MHz, rounded up from the bench's nanosecond settings
  localparam int S  = 7;    // 50 ns
  localparam int W  = 63;   // 500 ns
  localparam int T  = 250;  // 2000 ns calibration timeout
  localparam int H  = 250;  // 2000 ns CDR hold
  localparam int PD = 50;   // 400 ns poll period
  localparam int N  = 4;    // link samples

  // {done, errCode[1:0], iddq, sleep, calEn, dataEn, cdrReset, phyRdy}
  localparam logic [8:0] V_IDLE    = 9'b0_00_110000;
  localparam logic [8:0] V_PWRUP   = 9'b0_00_010000;
  localparam logic [8:0] V_WAKE    = 9'b0_00_000000;
  localparam logic [8:0] V_CAL     = 9'b0_00_001000;
  localparam logic [8:0] V_DROP    = 9'b0_00_000100;
  localparam logic [8:0] V_CDR     = 9'b0_00_000110;
  localparam logic [8:0] V_HOLD    = 9'b0_00_000111;
  localparam logic [8:0] V_POLL    = 9'b0_00_000101;
  localparam logic [8:0] V_DONE    = 9'b1_00_000101;
  localparam logic [8:0] V_ERRCAL  = 9'b0_01_110000;
  localparam logic [8:0] V_ERRLINK = 9'b0_10_110000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic calDone = 1'b0;
  logic linkUp = 1'b0;
  logic laneIddq, laneSleep, calEn, dataEn, cdrReset, phyRdy, done;
  logic [1:0] errCode;
  logic [8:0] obs;
  logic [8:0] prevObs;
  int edgeCnt = 0;
  int errors = 0;
  int checks = 0;
  bit monOn = 1'b0;

  int qAt[$];
  logic [8:0] qV[$];
  string qTag[$];

  always #4 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  rxlane_bringup #(
    .CLK_MHZ(125), .STEP_NS(50), .CALWAIT_NS(500), .CALTO_NS(2000),
    .HOLD_NS(2000), .POLL_NS(400), .POLL_MAX(N)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .calDone(calDone), .linkUp(linkUp),
    .laneIddq(laneIddq), .laneSleep(laneSleep), .calEn(calEn), .dataEn(dataEn),
    .cdrReset(cdrReset), .phyRdy(phyRdy), .done(done), .errCode(errCode)
  );

  assign obs = {done, errCode, laneIddq, laneSleep, calEn, dataEn, cdrReset, phyRdy};

  task automatic push(input int at, input logic [8:0] v, input string tag);
    qAt.push_back(at); qV.push_back(v); qTag.push_back(tag);
  endtask

  task automatic waitEdge(input int n);
    while (edgeCnt < n) @(negedge clk);
  endtask

  // monitor: every output change must match the next expected item
  always @(negedge clk) begin
    if (monOn && obs !== prevObs) begin
      checks++;
      if (qAt.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected change at edge %0d: actual %b expected no change (%b)",
                 edgeCnt, obs, prevObs);
      end else begin
        int at; logic [8:0] v; string tag;
        at = qAt.pop_front(); v = qV.pop_front(); tag = qTag.pop_front();
        if (at != edgeCnt || v !== obs) begin
          errors++;
          $display("FAIL %s actual %b at edge %0d, expected %b at edge %0d",
                   tag, obs, edgeCnt, v, at);
        end
      end
      prevObs = obs;
    end
  end

  // driver: mode 0 link up at sample k, 1 link timeout, 2 cal timeout, 3 abort in hold
  task automatic runSeq(input int dCal, input int mode, input int k);
    int e, c, x, p, a, last;
    e = edgeCnt + 1;
    c = e + S + W;
    x = c + dCal + 1;
    p = x + 3 * S + H;
    a = x + 3 * S + 10;
    push(e, V_PWRUP, "R2");
    push(e + S, V_WAKE, "R2");
    push(c, V_CAL, "R3");
    if (mode == 2) begin
      push(c + T, V_ERRCAL, "R4/R12");
      last = c + T;
    end else begin
      push(x, V_WAKE, "R5");
      push(x + S, V_DROP, "R5");
      push(x + 2 * S, V_CDR, "R6");
      push(x + 3 * S, V_HOLD, "R7");
      if (mode == 3) begin
        push(a + 1, V_IDLE, "R11");
        last = a + 1;
      end else begin
        push(p, V_POLL, "R8");
        if (mode == 0) begin
          push(p + k * PD, V_DONE, "R9/R12");
          last = p + k * PD;
        end else begin
          push(p + N * PD, V_ERRLINK, "R10/R12");
          last = p + N * PD;
        end
      end
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mode != 2 && !calDone) begin
      waitEdge(c + dCal);
      calDone = 1'b1;
    end
    if (mode == 3) begin
      waitEdge(a);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (mode == 0) begin
      waitEdge(p + (k - 1) * PD);
      linkUp = 1'b1;
    end
    waitEdge(last + 3);
    calDone = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;  // R1 reset state
        if (obs !== V_IDLE) begin
          errors++;
          $display("FAIL R1 reset state: actual %b expected %b", obs, V_IDLE);
        end
        prevObs = obs;
        monOn = 1'b1;
        repeat (20) @(negedge clk);             // R1: idle holds without start
        runSeq(5, 0, 2);                        // normal run, link on sample 2
        linkUp = 1'b0;
        repeat (60) @(negedge clk);             // R9: done holds after linkUp drops
        runSeq(0, 2, 0);                        // R4: calibration timeout
        calDone = 1'b1;                         // R5: held high before start
        runSeq(0, 1, 0);                        // R10: link timeout
        runSeq(12, 3, 0);                       // R11: abort during hold
        repeat (60) @(negedge clk);             // R11: stays idle
        runSeq(20, 0, 1);                       // link on first sample
        repeat (10) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R11 watchdog: actual still running, expected finished");
      end
    join_any
    disable fork;
    checks++;
    if (qAt.size() != 0) begin
      errors++;
      $display("FAIL %s missing change: actual none, expected %b at edge %0d",
               qTag[0], qV[0], qAt[0]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule